// File: doc/BRIEF.md
# Fractional-N Divider Word Update Aligner

This block sits between the register file of a fractional-N synthesizer and its divider datapath, and runs on the phase-detector clock. A single write strobe delivers a new integer divide word and a new fractional word together. The fractional word always reaches the divider through a fixed four-stage pipeline, because that is how long the modulator path takes. The integer word either goes straight to the divider or is held back through a matching four-stage delay. A select input chooses between the two. With the delay selected, the divider never runs with a new integer and a stale fraction, so it cannot briefly lock toward a wrong ratio.

The block also produces three control outputs. The first is a one-cycle modulator reset on each write, unless a hold input blocks it. The second is a load-state command for the divider counters while power-down is requested. The third is a strobe that marks the cycle in which the new words take effect. During power-down the latest written words are retained and all pipeline stages are flushed to them, so the block resumes from a consistent state when power-down is released.

Top module: `frac_n_word_aligner`

## Requirements
- R1: After reset, `int_o` and `frac_o` are 0, and `upd_o`, `mod_rst_o` and `load_o` are low.
- R2: Outside power-down, a fractional word written with `wr_i` high at clock edge t appears on `frac_o` right after edge t+3 (four edges including t), and `frac_o` does not change at any other time.
- R3: With `int_dly_i` = 0, an integer word written at edge t appears on `int_o` right after edge t.
- R4: With `int_dly_i` = 1, `int_o` shows the output of the four-stage integer delay, and it changes in the same cycle as `frac_o`, after edge t+3.
- R5: Outside power-down, `upd_o` is high for exactly the one cycle that follows edge t+3 of each write, and it is low otherwise.
- R6: A write that repeats the current integer word leaves `int_o` unchanged in every cycle, while the fractional word still updates.
- R7: When `mod_rst_hold_i` = 0 and `pwr_dn_i` = 0, a write at edge t makes `mod_rst_o` high for the one cycle after edge t.
- R8: When `mod_rst_hold_i` = 1, a write produces no pulse on `mod_rst_o`.
- R9: `load_o` is high in the cycle after every edge that samples `pwr_dn_i` high. While `load_o` is high, `upd_o` stays low. Writes made during power-down are still captured.
- R10: After power-down is released, `int_o` and `frac_o` equal the last written words at once, in both select settings, and no `upd_o` pulse follows for writes made during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-detector clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for both words |
| int_i | input | INT_W | New integer divide word |
| frac_i | input | FRAC_W | New fractional word |
| int_dly_i | input | 1 | 1 delays the integer word to match the fraction |
| mod_rst_hold_i | input | 1 | 1 blocks the modulator reset on writes |
| pwr_dn_i | input | 1 | Power-down request |
| int_o | output | INT_W | Effective integer word |
| frac_o | output | FRAC_W | Effective fractional word |
| upd_o | output | 1 | Marks the cycle in which the new words take effect |
| mod_rst_o | output | 1 | One-cycle modulator reset |
| load_o | output | 1 | Forces the divider counters to their load state |

## Verification
The main risk is a stage in the integer or fractional pipeline that holds a wrong value. That error shows on `int_o` or `frac_o` within four cycles of the write that should have overwritten it, as a mismatch against the words last written. A token chain that is out of step with the data shows as an `upd_o` pulse one cycle away from the change in `frac_o`. A power-down flush that is missing or incomplete shows in the first cycle after release, as an output that differs from the retained words. Random writes with both select settings and power-down bursts are compared against a cycle-level expectation on every cycle, so any of these errors is reported within a few cycles of where it starts.

// File: rtl/fnwa_pkg.sv
package fnwa_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 25;
  localparam int unsigned PIPE_DEPTH = 4;
endpackage

// File: rtl/fnwa_word_pipe.sv
module fnwa_word_pipe #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  input  logic         flush_i,
  output logic [W-1:0] head_o,
  output logic [W-1:0] tail_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] stg [DEPTH];
  logic [W-1:0] nxt_head;

  assign nxt_head = wr_i ? d_i : stg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else begin
      stg[0] <= nxt_head;
      // flush: every stage takes the staged word so release is seamless
      for (int k = 1; k < DEPTH; k++) stg[k] <= flush_i ? nxt_head : stg[k-1];
    end
  end

  assign head_o = stg[0];
  assign tail_o = stg[LAST];
endmodule

// File: rtl/fnwa_ctrl.sv
module fnwa_ctrl #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic hold_i,
  input  logic pd_i,
  output logic upd_o,
  output logic mod_rst_o,
  output logic load_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q     <= '0;
      mod_rst_o <= 1'b0;
      load_o    <= 1'b0;
    end else begin
      tok_q     <= pd_i ? '0 : {tok_q[DEPTH-2:0], wr_i};
      mod_rst_o <= wr_i & ~hold_i & ~pd_i;
      load_o    <= pd_i;
    end
  end

  assign upd_o = tok_q[LAST];
endmodule

// File: rtl/frac_n_word_aligner.sv
module frac_n_word_aligner
  import fnwa_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              int_dly_i,
  input  logic              mod_rst_hold_i,
  input  logic              pwr_dn_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              upd_o,
  output logic              mod_rst_o,
  output logic              load_o
);
  logic [INT_W-1:0]  int_head, int_tail;
  logic [FRAC_W-1:0] frac_head;

  fnwa_word_pipe #(.W(INT_W), .DEPTH(PIPE_DEPTH)) u_int_pipe (
    .clk_i, .rst_ni, .wr_i, .d_i(int_i), .flush_i(pwr_dn_i),
    .head_o(int_head), .tail_o(int_tail)
  );

  fnwa_word_pipe #(.W(FRAC_W), .DEPTH(PIPE_DEPTH)) u_frac_pipe (
    .clk_i, .rst_ni, .wr_i, .d_i(frac_i), .flush_i(pwr_dn_i),
    .head_o(frac_head), .tail_o(frac_o)
  );

  fnwa_ctrl #(.DEPTH(PIPE_DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .hold_i(mod_rst_hold_i), .pd_i(pwr_dn_i),
    .upd_o, .mod_rst_o, .load_o
  );

  assign int_o = int_dly_i ? int_tail : int_head;

  logic unused_head;
  assign unused_head = ^frac_head;
endmodule

// File: rtl/fnwa_chk.sv
module fnwa_chk #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [INT_W-1:0]  int_i,
  input logic              int_dly_i,
  input logic              mod_rst_hold_i,
  input logic              pwr_dn_i,
  input logic [INT_W-1:0]  int_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic              upd_o,
  input logic              mod_rst_o,
  input logic              load_o
);
  AST_MODRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !mod_rst_hold_i && !pwr_dn_i |=> mod_rst_o); // R7
  AST_MODRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_rst_hold_i |=> !mod_rst_o); // R8
  AST_LOAD_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> load_o); // R9
  AST_NO_UPD_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> !upd_o); // R9
  AST_INT_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !int_dly_i |=> int_dly_i || int_o == $past(int_i)); // R3
  AST_FRAC_ONLY_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o && !load_o |-> $stable(frac_o)); // R2
  AST_INT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dly_i && $stable(int_dly_i) && !upd_o && !load_o |-> $stable(int_o)); // R4
endmodule

bind frac_n_word_aligner fnwa_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i, .rst_ni, .wr_i, .int_i, .int_dly_i, .mod_rst_hold_i, .pwr_dn_i,
  .int_o, .frac_o, .upd_o, .mod_rst_o, .load_o
);

// File: tb/sim_frac_n_word_aligner.sv
`timescale 1ns/1ps
module sim_frac_n_word_aligner;
  localparam int IW = 16;
  localparam int FW = 25;
  localparam int D  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, sel = 0, hold = 0, pd = 0;
  logic [IW-1:0] iw = '0;
  logic [FW-1:0] fw = '0;
  logic [IW-1:0] int_o;
  logic [FW-1:0] frac_o;
  logic upd_o, mod_rst_o, load_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_n_word_aligner u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .int_i(iw), .frac_i(fw),
    .int_dly_i(sel), .mod_rst_hold_i(hold), .pwr_dn_i(pd),
    .int_o(int_o), .frac_o(frac_o), .upd_o(upd_o),
    .mod_rst_o(mod_rst_o), .load_o(load_o)
  );

  // expectation built from the requirement timings
  logic [IW-1:0] e_int_age [D];
  logic [FW-1:0] e_frac_age [D];
  bit            e_tok [D];
  logic [IW-1:0] s_int;
  logic [FW-1:0] s_frac;
  bit            e_mod, e_load;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < D; k++) begin e_int_age[k] = '0; e_frac_age[k] = '0; e_tok[k] = 0; end
      s_int = '0; s_frac = '0; e_mod = 0; e_load = 0;
    end else begin
      if (wr) begin s_int = iw; s_frac = fw; end
      e_mod  = wr && !hold && !pd;
      e_load = pd;
      if (pd) begin
        for (int k = 0; k < D; k++) begin e_int_age[k] = s_int; e_frac_age[k] = s_frac; e_tok[k] = 0; end
      end else begin
        for (int k = D-1; k > 0; k--) begin
          e_int_age[k] = e_int_age[k-1]; e_frac_age[k] = e_frac_age[k-1]; e_tok[k] = e_tok[k-1];
        end
        e_int_age[0] = s_int; e_frac_age[0] = s_frac; e_tok[0] = wr;
      end
    end
  end

  function automatic logic [IW-1:0] exp_int(input bit s);
    return s ? e_int_age[D-1] : e_int_age[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(frac_o == e_frac_age[D-1], "R2", 64'(frac_o), 64'(e_frac_age[D-1]));
    chk(int_o == exp_int(sel), sel ? "R4" : "R3", 64'(int_o), 64'(exp_int(sel)));
    chk(upd_o == e_tok[D-1], "R5", 64'(upd_o), 64'(e_tok[D-1]));
    chk(mod_rst_o == e_mod, hold ? "R8" : "R7", 64'(mod_rst_o), 64'(e_mod));
    chk(load_o == e_load, "R9", 64'(load_o), 64'(e_load));
  endtask

  task automatic step(input bit w, input logic [IW-1:0] i, input logic [FW-1:0] f);
    @(negedge clk);
    check_all();
    wr = w; iw = i; fw = f;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] keep;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int_o == 0 && frac_o == 0, "R1", 64'({int_o, frac_o}), 64'd0);
    chk(!upd_o && !mod_rst_o && !load_o, "R1", 64'({upd_o, mod_rst_o, load_o}), 64'd0);
    rst_n = 1;

    // R3 immediate, R7 pulse
    sel = 0; hold = 0;
    step(1, 16'h1234, 25'h0ABCDE);
    step(0, '0, '0);
    chk(int_o == 16'h1234, "R3", 64'(int_o), 64'h1234);
    chk(mod_rst_o == 1, "R7", 64'(mod_rst_o), 64'd1);
    repeat (4) step(0, '0, '0);

    // R6 repeated INT
    keep = int_o;
    step(1, keep, 25'h155555);
    for (int c = 0; c < 6; c++) begin
      step(0, '0, '0);
      chk(int_o == keep, "R6", 64'(int_o), 64'(keep));
    end
    chk(frac_o == 25'h155555, "R6", 64'(frac_o), 64'h155555);

    // R4 aligned, R8 held
    sel = 1; hold = 1;
    step(1, 16'hBEEF, 25'h1F0F0F);
    for (int c = 0; c < 3; c++) begin
      step(0, '0, '0);
      chk(int_o == keep && !mod_rst_o, "R4", 64'(int_o), 64'(keep));
    end
    step(0, '0, '0);
    chk(int_o == 16'hBEEF && frac_o == 25'h1F0F0F && upd_o, "R4", 64'(int_o), 64'hBEEF);

    // R10 write during power-down, then release
    hold = 0;
    @(negedge clk); check_all(); pd = 1;
    step(1, 16'h0F0F, 25'h012345);
    repeat (3) step(0, '0, '0);
    @(negedge clk); check_all(); pd = 0;
    for (int c = 0; c < 6; c++) begin
      step(0, '0, '0);
      chk(int_o == 16'h0F0F && frac_o == 25'h012345 && !upd_o, "R10", 64'(int_o), 64'h0F0F);
    end

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 31) == 0) sel = ~sel;
      if ($urandom_range(0, 15) == 0) hold = ~hold;
      if ($urandom_range(0, 63) == 0) pd = 1;
      else if (pd && $urandom_range(0, 3) == 0) pd = 0;
      step($urandom_range(0, 3) == 0, IW'($urandom), FW'($urandom));
    end
    step(0, '0, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule